// File: doc/BRIEF.md
# Instruction Fetch Queue with Half-Line Assembly

This block keeps a short queue of 32-bit instructions ready for a wide-issue core's dispatch stage. Program memory can only be read one full 256-bit line at a time, and every line address is 32-byte aligned. The queue is filled in fetch packets of 32 bytes. A packet may begin on a 16-byte boundary, and in that case it is assembled from the upper half of one line and the lower half of the next. Dispatch takes execute packets of one to eight instructions in a single pop. Any slot past the requested count reads as zero, which is the no-operation encoding, so the filler no-ops never come from memory.

The block can keep the most recently returned line in a retained-line register, which behaves like a one-line cache. When that is enabled and the stream is misaligned, each packet after the first takes its first half from the retained line, so only one memory read is issued per packet. A new start address empties the queue and restarts fetching from that point. A counter of issued reads lets the two modes be compared directly.

Top module: `fetch_queue`

## Requirements
- R1: After reset no memory request is raised and `readCount` is 0. Any pop with a nonzero count raises `popStall`, because the queue holds nothing.
- R2: A pop of n instructions (1 to 8, and n no larger than the number held) presents the next n instructions in program order in slots 0..n-1 of `popData` (slot i is bits 32i+31:32i) and consumes exactly n at the clock edge.
- R3: During a pop of n, slots n..7 of `popData` are all zero. Zero is the no-operation encoding.
- R4: A pop whose count exceeds the number held, or exceeds 8, raises `popStall` in the same cycle and consumes nothing. A count of 0 neither stalls nor consumes.
- R5: A new fetch packet is started only while 8 or fewer instructions are held, and the queue holds at most 16. After C instructions have been popped since a start and the queue has gone idle, exactly floor(C/8)+2 packets have been fetched.
- R6: Every request address has its low 5 bits at zero. A packet that starts on a 32-byte boundary costs exactly one read.
- R7: A packet that starts 16 bytes past a line boundary B takes its first four instructions from the upper half of line B and its last four from the lower half of line B+32. With reuse off, each such packet costs two reads.
- R8: With `reuseEn` high, a misaligned packet whose first line equals the most recently returned line takes that half from the retained line without a read. A misaligned stream of n packets then costs n+1 reads.
- R9: At most one read is outstanding at a time, and responses are appended in request order. A request that is not accepted keeps `memReqValid` high and holds its address.
- R10: A `startValid` pulse empties the queue, invalidates the retained line, and discards the response to any read issued before it. Fetching then resumes at `startAddr` rounded down to 16 bytes.
- R11: `readCount` counts the requests accepted since the last start, and a start clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Load a new start address and flush |
| startAddr | input | 32 | Byte address of the first instruction |
| reuseEn | input | 1 | Enable the retained-line register |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | 32-byte aligned line address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 256 | Line data, word j at bits 32j+31:32j |
| popValid | input | 1 | Dispatch pop request |
| popCount | input | 4 | Instructions to pop, 1 to 8 |
| popData | output | 256 | Execute packet, no-op filled |
| popStall | output | 1 | Pop cannot be served this cycle |
| readCount | output | 16 | Reads issued since the last start |

## Verification
The main sweep covers every pop size from 1 to 8, at both an aligned and a misaligned start, with reuse on and off. Pop size decides how often the refill threshold is crossed. The start alignment and the reuse mode separate the one-read, two-read and one-plus-n read costs, which appear in `readCount`. Separate runs use a memory stalled on `memReqReady`, which fixes the fill level exactly, to test stall without consumption. Further runs restart the stream while a read is still outstanding, which shows that the stale line is dropped and that the counter and the queue are cleared.

// File: rtl/fetch_queue_pkg.sv
package fetch_queue_pkg;

  // Which part of a line is appended to the queue
  typedef enum logic [1:0] {
    WR_FULL  = 2'd0,
    WR_UPPER = 2'd1,
    WR_LOWER = 2'd2
  } wrSel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } fetchState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   flush;
    logic   wrEn;
    logic   wrFromReuse;
    wrSel_e wrSel;
    logic   capLine;
  } ctlStrobe_t;

endpackage

// File: rtl/fetch_queue_ctrl.sv
module fetch_queue_ctrl
  import fetch_queue_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int LINE_INSTRS = 8,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int LVL_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              reuseEn,
  input  logic [LVL_W-1:0]  fillLevel,
  input  logic              reuseHit,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  output logic [ADDR_W-1:0] needLine,
  output ctlStrobe_t        strobe,
  output logic [CNT_W-1:0]  readCount
);

  localparam int LINE_BYTES = LINE_INSTRS * INSTR_W / 8;
  localparam int HALF_BYTES = LINE_BYTES / 2;
  localparam int HALF_BIT   = $clog2(HALF_BYTES);
  localparam int BUF_DEPTH  = 2 * LINE_INSTRS;
  localparam int THRESH     = BUF_DEPTH - LINE_INSTRS;

  fetchState_e      state;
  logic [ADDR_W-1:0] fpAddr;     // current packet address, 16-byte aligned
  logic              half;       // second half of a misaligned packet pending
  logic              stale;      // outstanding response belongs to an old stream

  logic   misaligned;
  wrSel_e curSel;
  logic   roomOk;
  logic   takeReuse;
  logic   accept;
  logic   rspUse;

  assign misaligned = fpAddr[HALF_BIT];

  always_comb begin
    if (!misaligned) begin
      needLine = fpAddr;
      curSel   = WR_FULL;
    end else if (half) begin
      needLine = fpAddr + ADDR_W'(HALF_BYTES);
      curSel   = WR_LOWER;
    end else begin
      needLine = fpAddr - ADDR_W'(HALF_BYTES);
      curSel   = WR_UPPER;
    end
  end

  assign roomOk      = half || (fillLevel <= LVL_W'(THRESH));
  assign takeReuse   = (state == ST_RUN) && roomOk && misaligned && !half && reuseEn && reuseHit;
  assign memReqValid = (state == ST_RUN) && roomOk && !takeReuse;
  assign memReqAddr  = needLine;
  assign accept      = memReqValid && memReqReady;
  assign rspUse      = (state == ST_WAIT) && memRspValid && !stale;

  always_comb begin
    strobe.flush       = startValid;
    strobe.wrEn        = !startValid && (takeReuse || rspUse);
    strobe.wrFromReuse = takeReuse;
    strobe.wrSel       = curSel;
    strobe.capLine     = rspUse && !startValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fpAddr    <= '0;
      half      <= 1'b0;
      stale     <= 1'b0;
      readCount <= '0;
    end else if (startValid) begin
      fpAddr    <= startAddr & ~ADDR_W'(HALF_BYTES - 1);
      half      <= 1'b0;
      readCount <= '0;
      if (accept || ((state == ST_WAIT) && !memRspValid)) begin
        state <= ST_WAIT;
        stale <= 1'b1;
      end else begin
        state <= ST_RUN;
        stale <= 1'b0;
      end
    end else begin
      case (state)
        ST_RUN: begin
          if (takeReuse) begin
            half <= 1'b1;
          end else if (accept) begin
            state     <= ST_WAIT;
            readCount <= readCount + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (memRspValid) begin
            state <= ST_RUN;
            if (stale) begin
              stale <= 1'b0;
            end else if (curSel == WR_UPPER) begin
              half <= 1'b1;
            end else begin
              half   <= 1'b0;
              fpAddr <= fpAddr + ADDR_W'(LINE_BYTES);
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fetch_queue_dpath.sv
module fetch_queue_dpath
  import fetch_queue_pkg::*;
#(
  parameter int INSTR_W     = 32,
  parameter int LINE_INSTRS = 8,
  parameter int ADDR_W      = 32,
  parameter int LVL_W       = 5,
  parameter int POPC_W      = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic [ADDR_W-1:0]              needLine,
  input  logic [LINE_INSTRS*INSTR_W-1:0] memRspData,
  input  logic                           popValid,
  input  logic [POPC_W-1:0]              popCount,
  output logic [LVL_W-1:0]               fillLevel,
  output logic                           reuseHit,
  output logic [LINE_INSTRS*INSTR_W-1:0] popData,
  output logic                           popStall
);

  localparam int LINE_W     = LINE_INSTRS * INSTR_W;
  localparam int HALF_W     = LINE_W / 2;
  localparam int HALF_INSTR = LINE_INSTRS / 2;
  localparam int BUF_DEPTH  = 2 * LINE_INSTRS;
  localparam int PTR_W      = $clog2(BUF_DEPTH);

  logic [INSTR_W-1:0] bufMem [BUF_DEPTH];
  logic [PTR_W-1:0]   head;
  logic [PTR_W-1:0]   tail;
  logic [LVL_W-1:0]   lvl;

  logic [LINE_W-1:0]  reuseLine;
  logic [ADDR_W-1:0]  reuseAddr;
  logic               reuseValid;

  logic [LINE_W-1:0]  srcLine;
  logic [LINE_W-1:0]  shifted;
  logic [INSTR_W-1:0] wrWords [LINE_INSTRS];
  logic [LVL_W-1:0]   wrCnt;
  logic               popFits;
  logic [LVL_W-1:0]   popTake;

  assign fillLevel = lvl;
  assign reuseHit  = reuseValid && (reuseAddr == needLine);

  // Source line and half selection
  assign srcLine = strobe.wrFromReuse ? reuseLine : memRspData;
  assign shifted = (strobe.wrSel == WR_UPPER) ? (srcLine >> HALF_W) : srcLine;

  always_comb begin
    if (!strobe.wrEn)                 wrCnt = '0;
    else if (strobe.wrSel == WR_FULL) wrCnt = LVL_W'(LINE_INSTRS);
    else                              wrCnt = LVL_W'(HALF_INSTR);
  end

  for (genvar j = 0; j < LINE_INSTRS; j++) begin : g_wrWord
    assign wrWords[j] = shifted[j*INSTR_W +: INSTR_W];
  end

  // Pop side
  assign popFits  = popValid && (popCount != '0)
                  && (popCount <= POPC_W'(LINE_INSTRS))
                  && (LVL_W'(popCount) <= lvl);
  assign popStall = popValid && (popCount != '0) && !popFits;
  assign popTake  = (popFits && !strobe.flush) ? LVL_W'(popCount) : '0;

  for (genvar i = 0; i < LINE_INSTRS; i++) begin : g_popSlot
    assign popData[i*INSTR_W +: INSTR_W] =
      (POPC_W'(i) < popCount) ? bufMem[head + PTR_W'(i)] : '0;
  end

  // Queue storage
  always_ff @(posedge clk) begin
    for (int j = 0; j < LINE_INSTRS; j++) begin
      if (LVL_W'(j) < wrCnt) begin
        bufMem[tail + PTR_W'(j)] <= wrWords[j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head <= '0;
      tail <= '0;
      lvl  <= '0;
    end else if (strobe.flush) begin
      head <= '0;
      tail <= '0;
      lvl  <= '0;
    end else begin
      head <= head + PTR_W'(popTake);
      tail <= tail + PTR_W'(wrCnt);
      lvl  <= lvl - popTake + wrCnt;
    end
  end

  // Retained line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reuseValid <= 1'b0;
      reuseAddr  <= '0;
      reuseLine  <= '0;
    end else if (strobe.flush) begin
      reuseValid <= 1'b0;
    end else if (strobe.capLine) begin
      reuseValid <= 1'b1;
      reuseAddr  <= needLine;
      reuseLine  <= memRspData;
    end
  end

endmodule

// File: rtl/fetch_queue.sv
module fetch_queue
  import fetch_queue_pkg::*;
#(
  parameter  int INSTR_W     = 32,
  parameter  int LINE_INSTRS = 8,
  parameter  int ADDR_W      = 32,
  parameter  int CNT_W       = 16,
  localparam int LINE_W      = LINE_INSTRS * INSTR_W,
  localparam int POPC_W      = $clog2(LINE_INSTRS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              reuseEn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [LINE_W-1:0] memRspData,
  input  logic              popValid,
  input  logic [POPC_W-1:0] popCount,
  output logic [LINE_W-1:0] popData,
  output logic              popStall,
  output logic [CNT_W-1:0]  readCount
);

  localparam int BUF_DEPTH = 2 * LINE_INSTRS;
  localparam int LVL_W     = $clog2(BUF_DEPTH) + 1;

  ctlStrobe_t        strobe;
  logic [LVL_W-1:0]  fillLevel;
  logic              reuseHit;
  logic [ADDR_W-1:0] needLine;

  fetch_queue_ctrl #(
    .INSTR_W(INSTR_W), .LINE_INSTRS(LINE_INSTRS), .ADDR_W(ADDR_W),
    .CNT_W(CNT_W), .LVL_W(LVL_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .reuseEn(reuseEn), .fillLevel(fillLevel), .reuseHit(reuseHit),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .needLine(needLine), .strobe(strobe),
    .readCount(readCount)
  );

  fetch_queue_dpath #(
    .INSTR_W(INSTR_W), .LINE_INSTRS(LINE_INSTRS), .ADDR_W(ADDR_W),
    .LVL_W(LVL_W), .POPC_W(POPC_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .needLine(needLine),
    .memRspData(memRspData), .popValid(popValid), .popCount(popCount),
    .fillLevel(fillLevel), .reuseHit(reuseHit), .popData(popData),
    .popStall(popStall)
  );

endmodule

// File: rtl/fetch_queue_chk.sv
module fetch_queue_chk #(
  parameter int INSTR_W     = 32,
  parameter int LINE_INSTRS = 8,
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int LVL_W       = 5,
  parameter int POPC_W      = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           startValid,
  input logic                           memReqValid,
  input logic                           memReqReady,
  input logic [ADDR_W-1:0]              memReqAddr,
  input logic                           memRspValid,
  input logic                           popValid,
  input logic [POPC_W-1:0]              popCount,
  input logic [LINE_INSTRS*INSTR_W-1:0] popData,
  input logic                           popStall,
  input logic [CNT_W-1:0]               readCount,
  input logic [LVL_W-1:0]               fillLevel
);

  localparam int LINE_BYTES = LINE_INSTRS * INSTR_W / 8;
  localparam int OFF_BITS   = $clog2(LINE_BYTES);
  localparam int BUF_DEPTH  = 2 * LINE_INSTRS;

  logic pendQ;
  logic nopOk;

  always_ff @(posedge clk) begin
    if (!rstN)                           pendQ <= 1'b0;
    else if (memReqValid && memReqReady) pendQ <= 1'b1;
    else if (memRspValid)                pendQ <= 1'b0;
  end

  always_comb begin
    nopOk = 1'b1;
    for (int i = 0; i < LINE_INSTRS; i++) begin
      if (POPC_W'(i) >= popCount && popData[i*INSTR_W +: INSTR_W] != '0) nopOk = 1'b0;
    end
  end

  // R6
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[OFF_BITS-1:0] == '0));

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendQ |-> !memReqValid);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady && !startValid) |=> (memReqValid && $stable(memReqAddr)));

  // R4
  stall_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popStall && !startValid) |=> (fillLevel >= $past(fillLevel)));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(BUF_DEPTH));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (fillLevel == '0 && readCount == '0));

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> ((readCount - $past(readCount)) <= CNT_W'(1)));

  // R3
  nop_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && popCount <= POPC_W'(LINE_INSTRS)) |-> nopOk);

endmodule

bind fetch_queue fetch_queue_chk #(
  .INSTR_W(INSTR_W), .LINE_INSTRS(LINE_INSTRS), .ADDR_W(ADDR_W),
  .CNT_W(CNT_W), .LVL_W(LVL_W), .POPC_W(POPC_W)
) chk_i (
  .clk(clk), .rstN(rstN), .startValid(startValid), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr), .memRspValid(memRspValid),
  .popValid(popValid), .popCount(popCount), .popData(popData), .popStall(popStall),
  .readCount(readCount), .fillLevel(fillLevel)
);

// File: tb/fetch_queue_tb_top.sv
module fetch_queue_tb_top;

  localparam int INSTR_W     = 32;
  localparam int LINE_INSTRS = 8;
  localparam int ADDR_W      = 32;
  localparam int CNT_W       = 16;
  localparam int LINE_W      = INSTR_W * LINE_INSTRS;
  localparam int POPC_W      = 4;

  logic              clk;
  logic              rstN;
  logic              startValid;
  logic [ADDR_W-1:0] startAddr;
  logic              reuseEn;
  logic              memReqValid;
  logic              memReqReady;
  logic [ADDR_W-1:0] memReqAddr;
  logic              memRspValid;
  logic [LINE_W-1:0] memRspData;
  logic              popValid;
  logic [POPC_W-1:0] popCount;
  logic [LINE_W-1:0] popData;
  logic              popStall;
  logic [CNT_W-1:0]  readCount;

  int checks = 0;
  int errors = 0;

  fetch_queue dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .reuseEn(reuseEn), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .popValid(popValid), .popCount(popCount), .popData(popData),
    .popStall(popStall), .readCount(readCount)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- memory model ----------------
  function automatic logic [31:0] instrAt(input logic [31:0] a);
    return 32'hA000_0000 ^ (a >> 2);
  endfunction

  function automatic logic [LINE_W-1:0] lineAt(input logic [31:0] b);
    logic [LINE_W-1:0] r;
    for (int j = 0; j < LINE_INSTRS; j++) r[j*32 +: 32] = instrAt(b + 32'(4 * j));
    return r;
  endfunction

  int          lat = 2;
  logic        freeze = 1'b0;
  logic        toggleReady = 1'b0;
  int          cyc = 0;
  int          pendCnt = 0;
  logic [31:0] pendAddr = '0;

  initial memReqReady = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    memReqReady = !freeze && (!toggleReady || cyc[0]);
  end

  initial begin
    memRspValid = 1'b0;
    memRspData  = '0;
  end
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memRspValid <= 1'b1;
        memRspData  <= lineAt(pendAddr);
      end
    end
    if (memReqValid && memReqReady) begin
      pendAddr <= memReqAddr;
      pendCnt  <= lat;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [31:0] streamBase;
  int          consumed;

  task automatic startStream(input logic [31:0] a, input logic ru);
    @(negedge clk);
    startValid = 1'b1;
    startAddr  = a;
    reuseEn    = ru;
    @(negedge clk);
    startValid = 1'b0;
    streamBase = a & ~32'hF;
    consumed   = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic popN(input int n);
    logic [LINE_W-1:0] expD;
    logic [LINE_W-1:0] mask;
    @(negedge clk);
    popValid = 1'b1;
    popCount = POPC_W'(n);
    #1;
    while (popStall) begin
      @(negedge clk);
      #1;
    end
    expD = '0;
    mask = '0;
    for (int i = 0; i < LINE_INSTRS; i++) begin
      if (i < n) begin
        expD[i*32 +: 32] = instrAt(streamBase + 32'(4 * (consumed + i)));
        mask[i*32 +: 32] = '1;
      end
    end
    // R2: requested slots in program order
    check((popData & mask) == expD, "R2", "pop data", popData & mask, expD);
    // R3: unused slots are no-op zero
    check((popData & ~mask) == '0, "R3", "no-op fill", popData & ~mask, '0);
    @(posedge clk);
    #1;
    popValid = 1'b0;
    consumed = consumed + n;
  endtask

  function automatic int expReads(input bit aligned, input bit ru, input int c);
    int n;
    n = c / 8 + 2;
    if (aligned) return n;
    if (ru) return n + 1;
    return 2 * n;
  endfunction

  task automatic checkReads(input bit aligned, input bit ru, input string tag);
    int e;
    e = expReads(aligned, ru, consumed);
    check(readCount == CNT_W'(e), tag, "read count",
          LINE_W'(readCount), LINE_W'(e));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rstN       = 1'b0;
    startValid = 1'b0;
    startAddr  = '0;
    reuseEn    = 1'b0;
    popValid   = 1'b0;
    popCount   = '0;
    streamBase = '0;
    consumed   = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle(3);

    // R1: reset state
    #1;
    check(memReqValid == 1'b0, "R1", "no request", LINE_W'(memReqValid), '0);
    check(readCount == '0, "R1", "read count", LINE_W'(readCount), '0);
    popValid = 1'b1;
    popCount = 4'd1;
    #1;
    check(popStall == 1'b1, "R1", "empty stall", LINE_W'(popStall), 1);
    popCount = 4'd0;
    #1;
    // R4: zero count does not stall
    check(popStall == 1'b0, "R4", "zero count", LINE_W'(popStall), 0);
    popValid = 1'b0;

    // Sweep: pop size x alignment x reuse mode
    for (int off = 0; off < 2; off++) begin
      for (int ru = 0; ru < 2; ru++) begin
        for (int k = 1; k <= 8; k++) begin
          toggleReady = k[0];
          lat = 1 + (k % 3);
          startStream(32'h1000 * (off * 2 + ru + 1) + 32'h100 * k + 32'(off * 16), ru[0]);
          settle(60);
          // R6 aligned, R7 split without reuse, R8 split with reuse
          checkReads(off == 0, ru[0], off == 0 ? "R6" : (ru != 0 ? "R8" : "R7"));
          for (int m = 0; m < 6; m++) popN(k);
          settle(60);
          // R5: refill threshold fixes the packet count
          checkReads(off == 0, ru[0], "R5");
        end
      end
    end

    // Frozen memory: exact level, stall without consumption
    toggleReady = 1'b0;
    lat = 2;
    startStream(32'h400, 1'b0);
    settle(40);
    freeze = 1'b1;
    popN(8);
    popN(5);
    settle(2);
    // R9: request held while not accepted
    check(memReqValid == 1'b1, "R9", "held valid", LINE_W'(memReqValid), 1);
    check(memReqAddr == 32'h440, "R9", "held addr", LINE_W'(memReqAddr), LINE_W'(32'h440));
    popValid = 1'b1;
    popCount = 4'd4;
    #1;
    // R4: count above the 3 held
    check(popStall == 1'b1, "R4", "over level", LINE_W'(popStall), 1);
    @(negedge clk);
    popValid = 1'b0;
    popN(3);   // R4: data continues where it was, nothing consumed by the stall
    @(negedge clk);
    popValid = 1'b1;
    popCount = 4'd1;
    #1;
    check(popStall == 1'b1, "R4", "empty frozen", LINE_W'(popStall), 1);
    @(negedge clk);
    popValid = 1'b0;
    freeze = 1'b0;
    settle(40);
    checkReads(1'b1, 1'b0, "R5");
    popValid = 1'b1;
    popCount = 4'd9;
    #1;
    // R4: count above 8
    check(popStall == 1'b1, "R4", "count nine", LINE_W'(popStall), 1);
    @(negedge clk);
    popValid = 1'b0;
    popN(2);

    // Restart while a read is outstanding
    lat = 6;
    startStream(32'h600, 1'b1);
    while (!(memReqValid && memReqReady)) @(negedge clk);
    settle(2);
    // R9: single outstanding read
    check(memReqValid == 1'b0, "R9", "one outstanding", LINE_W'(memReqValid), 0);
    startStream(32'h818, 1'b1);
    popValid = 1'b1;
    popCount = 4'd1;
    #1;
    // R10: queue emptied by the start
    check(popStall == 1'b1, "R10", "flushed", LINE_W'(popStall), 1);
    // R11: counter cleared
    check(readCount == '0, "R11", "count cleared", LINE_W'(readCount), '0);
    @(negedge clk);
    popValid = 1'b0;
    settle(80);
    checkReads(1'b0, 1'b1, "R10");
    for (int m = 0; m < 3; m++) popN(5);
    settle(80);
    checkReads(1'b0, 1'b1, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule